// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block schedules conversions on an eight-input multiplexed successive-approximation converter. Software picks channels through an enable register and chooses one of two operating modes. In single-pass mode every selected input is converted once, lowest index first, and then the block waits for the next trigger. In continuous mode the scan restarts after its last channel and runs until something stops it.

The block sends a channel number and a one-cycle start pulse to the converter, and the converter answers with a done pulse and a 10-bit result. Each result goes into a per-channel data register. The block also owns a self-clearing trigger bit, a completion flag and an active-low data-available pin. A two-bit rate field sets the spacing between conversion starts. A new trigger, a change of mode or any write to the enable register stops the scan that is running, and a trigger starts it again from the lowest enabled channel. The block starts no conversion while the converter power input is low.

Top module: `adc_scan_seq`

## Requirements
- R1: The enable register is at address 0x37. Channel 0..7 enable bits sit at bit positions 14, 13, 11, 10, 8, 7, 6, 5, and the register reads back at those positions. Only enabled channels are converted.
- R2: The control register is at address 0x36. Bit 13 is the mode (1 = continuous, 0 = single-pass), bit 12 is the trigger, bits 9:8 are the rate and bit 7 is the done flag. After reset it reads 0x2000.
- R3: In single-pass mode each enabled channel is started exactly once, in ascending index order, and then no further start occurs.
- R4: In continuous mode, after the highest enabled channel the scan starts again from the lowest enabled channel.
- R5: Writing 1 to bit 12 of 0x36 sets the trigger bit. The bit reads 1 until the scan begins and 0 from then on.
- R6: Any write to 0x37, a write to 0x36 that changes bit 13, or a write with bit 12 set stops the scan in progress. No further start follows, and the result of a conversion in flight is not stored. A trigger restarts the scan from the lowest enabled channel.
- R7: Bit 7 of 0x36 is set when a single-pass scan completes. It is cleared by a read strobe to any data address or by the start of a new scan, and it reads 0 in continuous mode.
- R8: dav_n is low while the done flag is set in single-pass mode. In continuous mode it is low for exactly PULSE_CYC clock cycles at the end of each scan.
- R9: Consecutive conversion starts within a scan are exactly BASE_CYC << rate clock cycles apart, given that the converter answers sooner than that.
- R10: The result of channel n reads at address 0x23 + n as a 10-bit straight-binary value in bits 9:0, with bits 15:10 zero. The data registers read 0 after reset.
- R11: While adc_pwr is 0, no conversion starts and a trigger stays pending with its bit reading 1. The scan begins once adc_pwr returns to 1.
- R12: A trigger with no channel enabled completes within a few cycles and starts no conversion. In single-pass mode it sets the done flag. In continuous mode it gives a single dav_n pulse and then stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| adc_pwr | input | 1 | Converter powered; 0 holds off all conversions |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 3 | Channel to convert, valid with conv_start |
| conv_done | input | 1 | Converter finished, one cycle |
| conv_result | input | RES_W | Conversion result, valid with conv_done |
| dav_n | output | 1 | Active-low data-available indicator |

## Verification
The assertions assume that the converter raises conv_done for a single cycle and only after a start that it accepted, and that reg_wr and reg_rd are never high together. The bench converter model always answers a fixed five cycles after each start. That is shorter than the smallest pacing interval, so the spacing of starts depends on the rate field alone. A done that arrives after an abort is discarded by design, so the bench may leave it in flight on purpose. All register traffic is driven away from the clock edge, one access at a time.

// File: rtl/adc_seq_pkg.sv
// Shared constants, types and helpers for the ADC scan sequencer.
// Assumes exactly eight analog channels; the enable-bit layout below is fixed.
package adc_seq_pkg;
    localparam int NCH  = 8;
    localparam int CH_W = 3;

    localparam logic [6:0] A_DATA = 7'h23;
    localparam logic [6:0] A_CFG  = 7'h36;
    localparam logic [6:0] A_EN   = 7'h37;

    localparam int B_MODE  = 13;
    localparam int B_TRIG  = 12;
    localparam int B_RATE  = 8;
    localparam int B_READY = 7;

    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CONV} seq_state_t;

    // Bit position of channel n's enable inside the enable register.
    function automatic int en_pos(input int n);
        return 14 - n - ((n >= 2) ? 1 : 0) - ((n >= 4) ? 1 : 0);
    endfunction

    // Index of the lowest set bit of v (0 when v is empty).
    function automatic logic [CH_W-1:0] lowest(input logic [NCH-1:0] v);
        logic [CH_W-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (v[i]) r = CH_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/adc_seq_pacer.sv
// Conversion pacing timer: after each issued start it blocks the next one
// for BASE_CYC << rate cycles. Assumes BASE_CYC >= 2.
module adc_seq_pacer #(
    parameter int BASE_CYC = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate,
    input  logic       issue,
    output logic       pace_ok
);
    localparam int MAXP = BASE_CYC * 8;
    localparam int CW   = $clog2(MAXP + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] period;

    assign period  = CW'(BASE_CYC) << rate;
    assign pace_ok = (cnt == '0);

    // Reload on every issued start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (issue)     cnt <= period - CW'(1);
        else if (cnt != '0) cnt <= cnt - CW'(1);
    end
endmodule

// File: rtl/adc_seq_results.sv
// Per-channel result storage: one write port fed by the sequencer, one
// combinational read port for the register interface.
module adc_seq_results
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CH_W-1:0]  widx,
    input  logic [RES_W-1:0] wdata,
    input  logic [CH_W-1:0]  ridx,
    output logic [RES_W-1:0] rdata
);
    logic [RES_W-1:0] mem [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        // Capture a finished conversion for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)                         mem[g] <= '0;
            else if (we && widx == CH_W'(g))    mem[g] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/adc_seq_ctrl.sv
// Scan state machine: walks the enabled channels in ascending order, issues
// paced start pulses, routes results, and owns the done flag and dav_n.
// Assumes conv_done arrives once per accepted start.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int PULSE_CYC = 125
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             abort,
    input  logic             auto_mode,
    input  logic [NCH-1:0]   en_mask,
    input  logic             pwr,
    input  logic             pace_ok,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic             rd_clr,
    output logic             start_ack,
    output logic             issue,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    output logic             res_we,
    output logic [CH_W-1:0]  res_idx,
    output logic [RES_W-1:0] res_data,
    output logic             ready,
    output logic             dav_n
);
    localparam int PW = $clog2(PULSE_CYC + 1);

    seq_state_t      state;
    logic [NCH-1:0]  remain;
    logic [NCH-1:0]  scan_mask;
    logic [NCH-1:0]  next_remain;
    logic [CH_W-1:0] cur_chan;
    logic [PW-1:0]   pulse_cnt;
    logic            finish_conv;
    logic            scan_end;

    assign start_ack   = (state == S_IDLE) && start_req && !abort;
    assign issue       = (state == S_WAIT) && pace_ok && pwr && !abort;
    assign finish_conv = (state == S_CONV) && conv_done && !abort;
    assign next_remain = remain & ~(NCH'(1) << cur_chan);
    assign scan_end    = (start_ack && en_mask == '0) ||
                         (finish_conv && next_remain == '0);

    assign res_we    = finish_conv;
    assign res_idx   = cur_chan;
    assign res_data  = conv_result;
    assign conv_chan = cur_chan;
    assign dav_n     = !(ready || pulse_cnt != '0);

    // Channel walk: idle, wait for pacing, wait for the converter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            remain     <= '0;
            scan_mask  <= '0;
            cur_chan   <= '0;
            conv_start <= 1'b0;
        end else begin
            conv_start <= issue;
            if (abort) begin
                state <= S_IDLE;
            end else begin
                case (state)
                    S_IDLE: if (start_ack) begin
                        scan_mask <= en_mask;
                        remain    <= en_mask;
                        state     <= (en_mask == '0) ? S_IDLE : S_WAIT;
                    end
                    S_WAIT: if (issue) begin
                        cur_chan <= lowest(remain);
                        state    <= S_CONV;
                    end
                    S_CONV: if (conv_done) begin
                        if (next_remain != '0) begin
                            remain <= next_remain;
                            state  <= S_WAIT;
                        end else if (auto_mode) begin
                            remain <= scan_mask;
                            state  <= S_WAIT;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // Done flag: set by a finished single-pass scan, held at 0 in continuous mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ready <= 1'b0;
        else if (auto_mode)          ready <= 1'b0;
        else if (scan_end)           ready <= 1'b1;
        else if (rd_clr || start_ack) ready <= 1'b0;
    end

    // Fixed-width low pulse on dav_n at the end of each continuous scan.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pulse_cnt <= '0;
        else if (scan_end && auto_mode)   pulse_cnt <= PW'(PULSE_CYC);
        else if (pulse_cnt != '0)         pulse_cnt <= pulse_cnt - PW'(1);
    end

    a_r3_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    a_r1_chan_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> scan_mask[conv_chan]);
    a_r7_auto_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && $past(auto_mode)) |-> !ready);
    a_r11_power: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(pwr));
endmodule

// File: rtl/adc_scan_seq.sv
// Top of the ADC scan sequencer: holds the control and enable registers,
// decodes register writes into trigger and abort events, and muxes read data.
// Assumes reg_wr and reg_rd are never asserted together.
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int BASE_CYC  = 250,
    parameter int PULSE_CYC = 125
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [6:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic             adc_pwr,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             dav_n
);
    localparam logic [6:0] A_DATA_END = A_DATA + 7'(NCH);

    logic             auto_mode, trig_pend;
    logic [1:0]       rate;
    logic [NCH-1:0]   en_mask, en_wr;
    logic [15:0]      en_rd;
    logic             wr_cfg, wr_en, abort, in_data;
    logic             start_ack, issue, pace_ok, ready, res_we;
    logic [CH_W-1:0]  res_idx, rd_idx;
    logic [RES_W-1:0] res_data, rd_val;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[15], reg_wdata[4:0]};
    assign wr_cfg  = reg_wr && reg_addr == A_CFG;
    assign wr_en   = reg_wr && reg_addr == A_EN;
    assign abort   = wr_en || (wr_cfg && (reg_wdata[B_TRIG] || reg_wdata[B_MODE] != auto_mode));
    assign in_data = reg_addr >= A_DATA && reg_addr < A_DATA_END;
    assign rd_idx  = CH_W'(reg_addr - A_DATA);

    for (genvar n = 0; n < NCH; n++) begin : g_en
        assign en_wr[n] = reg_wdata[en_pos(n)];
    end

    // Scatter the enable mask back to its register bit positions.
    always_comb begin
        en_rd = '0;
        for (int n = 0; n < NCH; n++) en_rd[en_pos(n)] = en_mask[n];
    end

    // Control and enable registers; trigger bit clears when its scan begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_mode <= 1'b1;
            trig_pend <= 1'b0;
            rate      <= '0;
            en_mask   <= '0;
        end else begin
            if (wr_cfg) begin
                auto_mode <= reg_wdata[B_MODE];
                rate      <= reg_wdata[B_RATE +: 2];
            end
            if (wr_en) en_mask <= en_wr;
            if (wr_cfg && reg_wdata[B_TRIG]) trig_pend <= 1'b1;
            else if (start_ack)              trig_pend <= 1'b0;
        end
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CFG) begin
            reg_rdata[B_MODE]       = auto_mode;
            reg_rdata[B_TRIG]       = trig_pend;
            reg_rdata[B_RATE +: 2]  = rate;
            reg_rdata[B_READY]      = ready;
        end else if (reg_addr == A_EN) begin
            reg_rdata = en_rd;
        end else if (in_data) begin
            reg_rdata[RES_W-1:0] = rd_val;
        end
    end

    adc_seq_pacer #(.BASE_CYC(BASE_CYC)) u_pacer (
        .clk(clk), .rst_n(rst_n), .rate(rate), .issue(issue), .pace_ok(pace_ok)
    );

    adc_seq_ctrl #(.RES_W(RES_W), .PULSE_CYC(PULSE_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_req(trig_pend && adc_pwr), .abort(abort), .auto_mode(auto_mode),
        .en_mask(en_mask), .pwr(adc_pwr), .pace_ok(pace_ok),
        .conv_done(conv_done), .conv_result(conv_result),
        .rd_clr(reg_rd && in_data),
        .start_ack(start_ack), .issue(issue), .conv_start(conv_start),
        .conv_chan(conv_chan), .res_we(res_we), .res_idx(res_idx),
        .res_data(res_data), .ready(ready), .dav_n(dav_n)
    );

    adc_seq_results #(.RES_W(RES_W)) u_results (
        .clk(clk), .rst_n(rst_n), .we(res_we), .widx(res_idx), .wdata(res_data),
        .ridx(rd_idx), .rdata(rd_val)
    );

    a_r5_trig_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ack && !(wr_cfg && reg_wdata[B_TRIG])) |=> !trig_pend);
endmodule

// File: tb/test_adc_scan_seq.sv
// Bench for the scan sequencer: behavioural converter, start logger, dav_n
// pulse meter, and directed plus exhaustive enable-mask sweeps.
module test_adc_scan_seq;
    localparam int BASE  = 16;
    localparam int PULSE = 6;
    localparam int LAT   = 5;

    logic        clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0, adc_pwr = 1;
    logic [6:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic        conv_start, conv_done = 0, dav_n;
    logic [2:0]  conv_chan;
    logic [9:0]  conv_result = 0;

    int nchk = 0, nerr = 0;
    int salt = 0;
    int cyc = 0, nlog = 0, nruns = 0, lowrun = 0, last_run = 0;
    int log_ch [1024];
    int log_t  [1024];
    int exp_data [8];
    int pos_tab [8] = '{14, 13, 11, 10, 8, 7, 6, 5};

    always #4 clk = ~clk;

    adc_scan_seq #(.RES_W(10), .BASE_CYC(BASE), .PULSE_CYC(PULSE)) i_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .adc_pwr(adc_pwr), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_result(conv_result), .dav_n(dav_n)
    );

    function automatic int model(input int ch, input int s);
        return (ch * 97 + s * 13 + 5) & 'h3FF;
    endfunction

    function automatic logic [15:0] mw(input int m);
        logic [15:0] w = '0;
        for (int i = 0; i < 8; i++) if (m[i]) w[pos_tab[i]] = 1'b1;
        return w;
    endfunction

    function automatic logic [15:0] cfgw(input int mode, input int trig, input int rate);
        return 16'((mode << 13) | (trig << 12) | (rate << 8));
    endfunction

    // Behavioural converter: answers LAT cycles after each start.
    logic [2:0] st_ch = 0;
    int st_cnt = 0;
    bit st_busy = 0;
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) begin
            st_busy <= 1; st_cnt <= LAT; st_ch <= conv_chan;
        end else if (st_busy) begin
            if (st_cnt == 1) begin
                conv_done   <= 1'b1;
                conv_result <= 10'(model(int'(st_ch), salt));
                st_busy     <= 0;
            end
            st_cnt <= st_cnt - 1;
        end
    end

    // Start logger and dav_n low-run meter.
    always @(posedge clk) begin
        cyc++;
        if (conv_start) begin
            log_ch[nlog % 1024] = int'(conv_chan);
            log_t[nlog % 1024]  = cyc;
            nlog++;
        end
        if (rst_n && !dav_n) lowrun++;
        else begin
            if (lowrun > 0) begin last_run = lowrun; nruns++; end
            lowrun = 0;
        end
    end

    task automatic chk(input string req, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic peek(input logic [6:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic rd_clear(input logic [6:0] a);
        @(negedge clk); reg_addr = a; reg_rd = 1;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic wait_ready(input int lim, output int waited);
        logic [15:0] d;
        waited = 0;
        do begin peek(7'h36, d); waited++; end while (!d[7] && waited < lim);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [15:0] d;
        int w, base, k, bad, firstbad, n0;
        repeat (5) @(negedge clk);
        rst_n = 1;

        // Reset state (R2, R1, R10, R8).
        peek(7'h36, d); chk("R2 reset cfg", int'(d), 'h2000);
        peek(7'h37, d); chk("R1 reset enable", int'(d), 0);
        for (int c = 0; c < 8; c++) begin
            peek(7'(8'h23 + c), d); chk("R10 reset data", int'(d), 0); exp_data[c] = 0;
        end
        chk("R8 reset dav_n", int'(dav_n), 1);

        // Exhaustive enable-mask sweep, single-pass at rate 0 (R1 R3 R7 R8 R10 R12).
        for (int m = 0; m < 256; m++) begin
            salt = m + 1;
            wr(7'h37, mw(m));
            peek(7'h37, d); chk("R1 enable readback", int'(d), int'(mw(m)));
            base = nlog;
            wr(7'h36, cfgw(0, 1, 0));
            wait_ready(2000, w);
            peek(7'h36, d); chk("R7 done flag set", int'(d[7]), 1);
            if (m == 0) chk("R12 empty scan quick", int'(w < 10), 1);
            chk("R8 dav_n low when done", int'(dav_n), 0);
            repeat (2) @(negedge clk);
            k = 0; bad = 0;
            for (int c = 0; c < 8; c++) if (m[c]) begin
                if (log_ch[(base + k) % 1024] != c) bad++;
                k++;
                exp_data[c] = model(c, salt);
            end
            chk("R3 start order mismatches", bad, 0);
            chk("R3 start count", nlog - base, k);
            for (int c = 0; c < 8; c++) begin
                peek(7'(8'h23 + c), d); chk("R10 result", int'(d), exp_data[c]);
            end
            rd_clear(7'h23);
            peek(7'h36, d); chk("R7 cleared by data read", int'(d[7]), 0);
            chk("R8 dav_n high after clear", int'(dav_n), 1);
        end

        // Rate sweep (R9), all channels enabled.
        wr(7'h37, mw(255));
        for (int r = 0; r < 4; r++) begin
            base = nlog; salt = 300 + r;
            wr(7'h36, cfgw(0, 1, r));
            wait_ready(5000, w);
            bad = 0; firstbad = 0;
            for (int i = 1; i < 8; i++) begin
                k = log_t[(base + i) % 1024] - log_t[(base + i - 1) % 1024];
                if (k != (BASE << r)) begin if (bad == 0) firstbad = k; bad++; end
            end
            chk("R9 start spacing", bad == 0 ? (BASE << r) : firstbad, BASE << r);
            rd_clear(7'h23);
        end
        wr(7'h36, cfgw(0, 0, 0));

        // New scan clears done flag and trigger bit (R7, R5).
        salt = 400;
        wr(7'h36, cfgw(0, 1, 0));
        wait_ready(2000, w);
        wr(7'h36, cfgw(0, 1, 0));
        repeat (5) @(negedge clk);
        peek(7'h36, d);
        chk("R7 cleared by new scan", int'(d[7]), 0);
        chk("R5 trigger self-clear", int'(d[12]), 0);
        wait_ready(2000, w);
        rd_clear(7'h23);

        // Power hold-off (R11, R5).
        adc_pwr = 0; base = nlog; salt = 500;
        wr(7'h36, cfgw(0, 1, 0));
        repeat (100) @(negedge clk);
        chk("R11 no start while unpowered", nlog - base, 0);
        peek(7'h36, d); chk("R11 trigger held pending", int'(d[12]), 1);
        adc_pwr = 1;
        wait_ready(2000, w);
        peek(7'h36, d); chk("R5 trigger cleared after start", int'(d[12]), 0);
        chk("R11 scan runs after power", nlog - base, 8);
        for (int c = 0; c < 8; c++) exp_data[c] = model(c, salt);
        rd_clear(7'h23);

        // Abort by enable rewrite mid-conversion (R6).
        salt = 600; base = nlog;
        wr(7'h36, cfgw(0, 1, 0));
        wait (nlog >= base + 3);
        wr(7'h37, mw(255));
        n0 = nlog;
        repeat (300) @(negedge clk);
        chk("R6 no start after enable rewrite", nlog - n0, 0);
        chk("R6 start count before abort", n0 - base, 3);
        peek(7'h36, d); chk("R6 aborted scan not done", int'(d[7]), 0);
        peek(7'h23, d); chk("R6 ch0 stored", int'(d), model(0, 600));
        peek(7'h24, d); chk("R6 ch1 stored", int'(d), model(1, 600));
        peek(7'h25, d); chk("R6 in-flight ch2 discarded", int'(d), exp_data[2]);

        // Continuous repeat, then abort by mode change (R4, R6).
        base = nlog;
        wr(7'h36, cfgw(1, 1, 0));
        wait (nlog >= base + 10);
        chk("R4 wrap to lowest", log_ch[(base + 8) % 1024], 0);
        chk("R4 wrap second", log_ch[(base + 9) % 1024], 1);
        wr(7'h36, cfgw(0, 0, 0));
        n0 = nlog;
        repeat (300) @(negedge clk);
        chk("R6 no start after mode change", nlog - n0, 0);

        // Retrigger restarts from lowest channel (R6).
        base = nlog;
        wr(7'h36, cfgw(1, 1, 0));
        wait (nlog >= base + 3);
        wr(7'h36, cfgw(1, 1, 0));
        n0 = nlog;
        wait (nlog >= n0 + 2);
        chk("R6 restart first", log_ch[n0 % 1024], 0);
        chk("R6 restart second", log_ch[(n0 + 1) % 1024], 1);
        wr(7'h36, cfgw(0, 0, 0));

        // Continuous-mode pulse and flag (R8, R7, R4) with channels 1 and 6.
        wr(7'h37, mw('h42));
        k = nruns; base = nlog;
        wr(7'h36, cfgw(1, 1, 0));
        wait (nruns >= k + 3);
        chk("R8 pulse width", last_run, PULSE);
        peek(7'h36, d); chk("R7 flag zero in continuous", int'(d[7]), 0);
        bad = 0;
        for (int i = 0; i < 6; i++) if (log_ch[(base + i) % 1024] != ((i % 2) ? 6 : 1)) bad++;
        chk("R4 repeating order 1,6", bad, 0);
        wr(7'h36, cfgw(0, 0, 0));
        repeat (20) @(negedge clk);

        // Empty mask in continuous mode (R12).
        wr(7'h37, 16'h0000);
        k = nruns; base = nlog;
        wr(7'h36, cfgw(1, 1, 0));
        repeat (200) @(negedge clk);
        chk("R12 single pulse", nruns - k, 1);
        chk("R12 pulse width", last_run, PULSE);
        chk("R12 no conversion", nlog - base, 0);

        summary();
    end
endmodule